// File: doc/BRIEF.md
# CAN Frame Timestamp Counter

This block keeps a free-running count that serves as the time base for stamping CAN frames. The count advances on a bit-clock enable. While a frame occupies the bus, it steps once for each bit that is received or transmitted, as signalled by a bit strobe from the bit-timing logic. While the bus is idle, an internal divider steps it at the nominal bit rate, once every `BIT_CLKS` system clocks. A processor can read the live count at any time and overwrite it.

When the identifier field of a frame begins, the block holds a copy of the count. The copy is delivered as the frame's timestamp only if the frame later completes successfully. An aborted frame leaves the last delivered timestamp untouched. The storage that files the timestamp into a message slot sits outside this block, and so does the logic that generates the bit strobes.

Top module: `can_stamp_timer`

## Requirements
- R1: After a synchronous active-low reset, `count_o` is 0, `stamp_o` is 0 and `stamp_vld_o` is 0.
- R2: While `bus_active_i` is 1, `count_o` rises by one in the cycle after each cycle in which `bit_tick_i` is 1. It stays unchanged after a cycle in which `bit_tick_i` is 0.
- R3: While `bus_active_i` is 0, `bit_tick_i` is ignored. The count rises by one every `BIT_CLKS` clocks, and the first step becomes visible `BIT_CLKS` cycles after the first idle cycle.
- R4: The count is `CNT_W` bits wide. A step from the all-ones value gives 0.
- R5: When `wr_en_i` is 1, the next cycle shows `wr_data_i` on `count_o`. A step in the same cycle is lost. Later steps count on from the written value.
- R6: A cycle with `id_start_i` at 1 captures the value `count_o` shows in that cycle, before any step or write at that edge, and marks the capture pending.
- R7: When `frame_ok_i` is 1 and a capture is pending, the next cycle shows `stamp_vld_o` at 1 for exactly one cycle, with `stamp_o` equal to the capture. The pending mark is then cleared, so a second `frame_ok_i` gives no strobe. `stamp_o` holds its value between commits.
- R8: `frame_abort_i` discards a pending capture. A later `frame_ok_i` gives no strobe and leaves `stamp_o` unchanged.
- R9: An `id_start_i` replaces a pending capture that was never committed. The next commit delivers the newer value.
- R10: A `frame_ok_i` with no pending capture, for example the first one after reset, gives no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_tick_i | input | 1 | One-cycle strobe per bit on the bus |
| bus_active_i | input | 1 | 1 while a frame occupies the bus |
| id_start_i | input | 1 | Strobe at the start of the identifier field |
| frame_ok_i | input | 1 | Strobe when a frame completes successfully |
| frame_abort_i | input | 1 | Strobe when a frame ends by error or lost arbitration |
| wr_en_i | input | 1 | Processor write enable for the count |
| wr_data_i | input | CNT_W | Processor write value |
| count_o | output | CNT_W | Live count, also the processor read value |
| stamp_o | output | CNT_W | Last committed timestamp |
| stamp_vld_o | output | 1 | One-cycle strobe for a new timestamp |

## Verification
The bench builds the block with `CNT_W` = 16, so the all-ones-to-zero wrap is reached directly by a processor write of 0xFFFF. It sets `BIT_CLKS` = 4, which keeps idle-rate stepping short: several idle steps, and the exact cycle of the first one after the bus goes quiet, fit in a few dozen cycles. With both values, strobes that coincide in one cycle (write with tick, identifier start with tick) can be checked cycle by cycle.

// File: rtl/can_stamp_pkg.sv
// Package: shared defaults and the frame-event bundle for the timestamp timer.
// Assumes: every strobe in the bundle lasts one system clock.
package can_stamp_pkg;
    localparam int unsigned DEF_CNT_W    = 16;
    localparam int unsigned DEF_BIT_CLKS = 8;

    typedef struct packed {
        logic id_start;
        logic ok;
        logic abort;
    } frame_ev_t;
endpackage

// File: rtl/can_step_gen.sv
// Step generator: while a frame is on the bus it passes the bit strobe through.
// While the bus is idle it makes one step every BIT_CLKS clocks from its own divider.
// Assumes: bit_tick_i comes from the bit-timing logic and lasts one clock.
module can_step_gen #(
    parameter int unsigned BIT_CLKS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_tick_i,
    input  logic bus_active_i,
    output logic step_o
);
    localparam int unsigned DIV_W = (BIT_CLKS > 1) ? $clog2(BIT_CLKS) : 1;

    generate
        if (BIT_CLKS > 1) begin : g_div
            localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(BIT_CLKS - 1);
            logic [DIV_W-1:0] div_q;

            // Idle divider: restarts whenever the bus is busy, wraps after DIV_LAST.
            always_ff @(posedge clk) begin
                if (!rst_n || bus_active_i) div_q <= '0;
                else if (div_q == DIV_LAST) div_q <= '0;
                else                        div_q <= div_q + 1'b1;
            end

            // Step select: bit strobe while busy, divider terminal count while idle.
            always_comb begin
                step_o = bus_active_i ? bit_tick_i : (div_q == DIV_LAST);
            end

            // R3: two idle steps never come back to back when the divider is longer than one.
            a_r3_idle_spacing: assert property (@(posedge clk) disable iff (!rst_n)
                (!bus_active_i && step_o) |=> (bus_active_i || !step_o));
        end else begin : g_nodiv
            // Step select with no divider: every idle clock is a step.
            always_comb begin
                step_o = bus_active_i ? bit_tick_i : 1'b1;
            end
        end
    endgenerate
endmodule

// File: rtl/can_free_cnt.sv
// Free-running counter: counts steps and wraps at all ones. A processor write wins over a step.
// Assumes: step_i and wr_en_i are synchronous to clk.
module can_free_cnt #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_i,
    input  logic             wr_en_i,
    input  logic [CNT_W-1:0] wr_data_i,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q;

    // Count register: reset, then write, then step.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_q <= '0;
        else if (wr_en_i) cnt_q <= wr_data_i;
        else if (step_i)  cnt_q <= cnt_q + 1'b1;
    end

    assign cnt_o = cnt_q;

    // R4: a step from all ones lands on zero.
    a_r4_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en_i && step_i && cnt_q == CNT_MAX) |=> (cnt_q == '0));
    // R5: a write shows its data next cycle, whatever the step input did.
    a_r5_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> (cnt_q == $past(wr_data_i)));
    // R2: with no write and no step the count holds.
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en_i && !step_i) |=> $stable(cnt_q));
endmodule

// File: rtl/can_stamp_hold.sv
// Timestamp holder: captures the count at identifier start and commits it on frame success.
// Abort drops the capture. A new identifier start replaces an uncommitted one.
// Assumes: the frame strobes last one clock each.
module can_stamp_hold #(
    parameter int unsigned CNT_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  can_stamp_pkg::frame_ev_t ev_i,
    input  logic [CNT_W-1:0]        cnt_i,
    output logic [CNT_W-1:0]        stamp_o,
    output logic                    stamp_vld_o
);
    logic [CNT_W-1:0] cap_q;
    logic             pend_q;
    logic             commit;

    // Commit condition: success with a capture waiting.
    always_comb begin
        commit = ev_i.ok && pend_q;
    end

    // Capture register and pending mark: a new start wins over ok and abort.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q  <= '0;
            pend_q <= 1'b0;
        end else if (ev_i.id_start) begin
            cap_q  <= cnt_i;
            pend_q <= 1'b1;
        end else if (ev_i.ok || ev_i.abort) begin
            pend_q <= 1'b0;
        end
    end

    // Output stage: deliver the capture and pulse the valid strobe on commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stamp_o     <= '0;
            stamp_vld_o <= 1'b0;
        end else begin
            stamp_vld_o <= commit;
            if (commit) stamp_o <= cap_q;
        end
    end

    // R6: an identifier start always leaves a pending capture.
    a_r6_capture_pending: assert property (@(posedge clk) disable iff (!rst_n)
        ev_i.id_start |=> pend_q);
    // R7: a strobe only follows a success that met a pending capture.
    a_r7_strobe_source: assert property (@(posedge clk) disable iff (!rst_n)
        stamp_vld_o |-> $past(ev_i.ok && pend_q));
    // R8: after an abort with no new start, a success yields no strobe.
    a_r8_abort_drop: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ev_i.abort && !ev_i.id_start) && !ev_i.id_start && ev_i.ok) |=> !stamp_vld_o);
    // R7: the stamp changes only together with the strobe.
    a_r7_stamp_steady: assert property (@(posedge clk) disable iff (!rst_n)
        !stamp_vld_o |-> $stable(stamp_o));
endmodule

// File: rtl/can_stamp_timer.sv
// Top: bit-clocked timestamp timer. Joins the step generator, the free counter and the
// timestamp holder. Assumes all inputs are synchronous to clk; reset is active low and synchronous.
module can_stamp_timer #(
    parameter int unsigned CNT_W    = can_stamp_pkg::DEF_CNT_W,
    parameter int unsigned BIT_CLKS = can_stamp_pkg::DEF_BIT_CLKS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_tick_i,
    input  logic             bus_active_i,
    input  logic             id_start_i,
    input  logic             frame_ok_i,
    input  logic             frame_abort_i,
    input  logic             wr_en_i,
    input  logic [CNT_W-1:0] wr_data_i,
    output logic [CNT_W-1:0] count_o,
    output logic [CNT_W-1:0] stamp_o,
    output logic             stamp_vld_o
);
    logic                     step;
    can_stamp_pkg::frame_ev_t ev;

    // Event bundle: gather the frame strobes for the holder.
    always_comb begin
        ev.id_start = id_start_i;
        ev.ok       = frame_ok_i;
        ev.abort    = frame_abort_i;
    end

    can_step_gen #(.BIT_CLKS(BIT_CLKS)) u_step (
        .clk          (clk),
        .rst_n        (rst_n),
        .bit_tick_i   (bit_tick_i),
        .bus_active_i (bus_active_i),
        .step_o       (step)
    );

    can_free_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_i    (step),
        .wr_en_i   (wr_en_i),
        .wr_data_i (wr_data_i),
        .cnt_o     (count_o)
    );

    can_stamp_hold #(.CNT_W(CNT_W)) u_hold (
        .clk         (clk),
        .rst_n       (rst_n),
        .ev_i        (ev),
        .cnt_i       (count_o),
        .stamp_o     (stamp_o),
        .stamp_vld_o (stamp_vld_o)
    );

    // R2: while busy with no write, the count holds after a cycle without a bit strobe.
    a_r2_busy_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_active_i && !bit_tick_i && !wr_en_i) |=> $stable(count_o));
endmodule

// File: tb/sim_can_stamp_timer.sv
module sim_can_stamp_timer;
    localparam int CLK_NS = 10;
    localparam int W      = 16;
    localparam int BCLK   = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_tick = 0, bus_act = 1, id_st = 0, f_ok = 0, f_ab = 0, wr_en = 0;
    logic [W-1:0] wr_data = '0;
    logic [W-1:0] count, stamp;
    logic stamp_vld;
    int total = 0, bad = 0;
    bit done = 0;

    always #(CLK_NS/2) clk = ~clk;

    can_stamp_timer #(.CNT_W(W), .BIT_CLKS(BCLK)) u0 (
        .clk(clk), .rst_n(rst_n), .bit_tick_i(bit_tick), .bus_active_i(bus_act),
        .id_start_i(id_st), .frame_ok_i(f_ok), .frame_abort_i(f_ab),
        .wr_en_i(wr_en), .wr_data_i(wr_data),
        .count_o(count), .stamp_o(stamp), .stamp_vld_o(stamp_vld));

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [W-1:0] v);
        wr_en = 1; wr_data = v; cyc(1); wr_en = 0;
    endtask

    task automatic ok_pulse();
        f_ok = 1; cyc(1); f_ok = 0;
    endtask

    // R1 and R10: reset values, then a success strobe with nothing pending.
    task automatic t_reset();
        rst_n = 0; bus_act = 1; cyc(3); rst_n = 1;
        chk("R1 count", count, '0);
        chk("R1 stamp", stamp, '0);
        chk("R1 vld", {15'd0, stamp_vld}, 16'd0);
        ok_pulse();
        chk("R10 no strobe", {15'd0, stamp_vld}, 16'd0);
    endtask

    // R2: counts only the cycles with a bit strobe while busy.
    task automatic t_bits();
        logic [11:0] pat = 12'b1011_0011_1101;
        int n = 0;
        bus_act = 1; wr(16'h0010);
        for (int i = 0; i < 12; i++) begin
            bit_tick = pat[i]; n += pat[i]; cyc(1);
        end
        bit_tick = 0;
        chk("R2 bit count", count, 16'h0010 + 16'(n));
        cyc(3);
        chk("R2 hold", count, 16'h0010 + 16'(n));
    endtask

    // R3: idle rate from the divider, bit strobe ignored.
    task automatic t_idle();
        bus_act = 1; wr(16'h0000);
        bus_act = 0; bit_tick = 1;
        cyc(BCLK - 1);
        chk("R3 before first step", count, 16'd0);
        cyc(1);
        chk("R3 first step", count, 16'd1);
        cyc(4 * BCLK);
        chk("R3 idle rate", count, 16'd5);
        bit_tick = 0; bus_act = 1; cyc(1);
    endtask

    // R4: wrap from all ones.
    task automatic t_wrap();
        bus_act = 1; wr(16'hFFFF);
        chk("R4 loaded", count, 16'hFFFF);
        bit_tick = 1; cyc(1); bit_tick = 0;
        chk("R4 wrap", count, 16'h0000);
        bit_tick = 1; cyc(1); bit_tick = 0;
        chk("R4 after wrap", count, 16'h0001);
    endtask

    // R5: write beats a same-cycle step; counting resumes from it.
    task automatic t_write_prio();
        bus_act = 1; bit_tick = 1; wr(16'h2222);
        chk("R5 write wins", count, 16'h2222);
        cyc(1); bit_tick = 0;
        chk("R5 resume", count, 16'h2223);
    endtask

    // R6 and R7: capture with a same-cycle tick, commit once.
    task automatic t_stamp();
        bus_act = 1; wr(16'h1234);
        id_st = 1; bit_tick = 1; cyc(1); id_st = 0;
        cyc(2); bit_tick = 0;
        chk("R6 count moved on", count, 16'h1237);
        ok_pulse();
        chk("R7 strobe", {15'd0, stamp_vld}, 16'd1);
        chk("R6 captured value", stamp, 16'h1234);
        cyc(1);
        chk("R7 one cycle", {15'd0, stamp_vld}, 16'd0);
        ok_pulse();
        chk("R7 second ok no strobe", {15'd0, stamp_vld}, 16'd0);
        chk("R7 stamp held", stamp, 16'h1234);
    endtask

    // R8: abort discards the capture.
    task automatic t_abort();
        bus_act = 1; wr(16'h0500);
        id_st = 1; cyc(1); id_st = 0;
        f_ab = 1; cyc(1); f_ab = 0;
        ok_pulse();
        chk("R8 no strobe", {15'd0, stamp_vld}, 16'd0);
        chk("R8 stamp unchanged", stamp, 16'h1234);
    endtask

    // R9: a second start replaces the pending capture.
    task automatic t_overwrite();
        bus_act = 1; wr(16'h0700);
        id_st = 1; cyc(1); id_st = 0;
        bit_tick = 1; cyc(3); bit_tick = 0;
        id_st = 1; cyc(1); id_st = 0;
        ok_pulse();
        chk("R9 strobe", {15'd0, stamp_vld}, 16'd1);
        chk("R9 newer capture", stamp, 16'h0703);
    endtask

    initial begin
        cyc(1);
        t_reset();
        t_bits();
        t_idle();
        t_wrap();
        t_write_prio();
        t_stamp();
        t_abort();
        t_overwrite();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_NS * 200000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule